// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a 512-byte serial EEPROM that sits on a two-wire bus. The block's own clock oversamples the bus clock and data lines. The block pulls the data line low through an open-drain enable, and it never drives the line high. Two strap inputs give the chip-select bits that the device-address byte must match. The remaining bit in that byte's address field is taken as the top bit of the 9-bit word address. A write-protect input makes the whole array read-only.

The host writes through a device-address byte, one word-address byte and up to sixteen data bytes. These bytes collect in a page buffer. The buffer reaches the storage array only after the stop condition, during a timed busy period. While the block is busy it answers nothing, so a host can poll it with a device address until it acknowledges. Reads return the byte at the internal pointer. The host may read one byte, or keep acknowledging to stream through the whole array with wrap-around. A random read sets the pointer first with a write that carries only a word address.

Top module: `ee2w_slave_engine`

## Requirements
- R1: A start condition (data line falls while the clock line is high) begins a new device-address byte from any state, unless the block is busy. A stop condition (data line rises while the clock line is high) returns the block to idle, and the block then ignores bytes until the next start.
- R2: The block acknowledges a device-address byte by holding the data line low during the ninth clock, and only when bits 7..4 are 1010 and bits 3..2 equal `strap_i[1:0]`. Bit 1 is the page bit and bit 0 selects read when 1. A byte that does not match gets no acknowledge.
- R3: The block samples incoming bits on the rising edge of the bus clock. It changes its data-line drive only while the bus clock is low.
- R4: A write built from a device address with page bit P, a word-address byte B and one data byte stores that byte at address {P,B}. The block acknowledges every byte.
- R5: In a multi-byte write, only the low 4 address bits increment after each data byte, so a 17th byte overwrites the first byte of the same 16-byte page.
- R6: Data reaches the array only after the stop condition. For the next TWR_CYC clock cycles (at least 16) the block ignores the bus and acknowledges no device address. After that period it acknowledges again.
- R7: When `wp_i` is 1 at the stop condition, the array stays unchanged, although the block still acknowledges every byte of the write.
- R8: A read without a preceding word address returns the byte at the pointer. The pointer is left at the last address accessed plus one, and the page bit of a read device address does not change it.
- R9: A random read returns the byte at the address loaded by the preceding address-only write.
- R10: While the host acknowledges each read byte, the block sends the next address, wrapping from 0x1FF to 0x000. When the host does not acknowledge, the read ends.
- R11: A write that stops before any data byte starts no busy period and only loads the pointer.
- R12: After reset the data-line drive is released, the block is idle and not busy, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Hardwired chip-select bits |
| wp_i | input | 1 | 1 protects the whole array |

## Verification
Two functions can fall in the same cycle. One is the busy period that copies the page buffer into the array. The other is the detection of a new start and device address from a host that polls straight after its stop. The bench provokes this overlap by sending a device address at once after each committing stop. It judges the result by the missing acknowledge on that poll, by a later poll that is acknowledged, and by reading the committed bytes back unchanged.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DACK, S_WADR, S_WAACK, S_WDAT, S_WDACK, S_RDAT, S_RACK
    } ee2w_state_e;
endpackage

// File: rtl/ee2w_line_cond.sv
module ee2w_line_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC:0] scl_sr_q, sda_sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
        end else begin
            scl_sr_q <= {scl_sr_q[SYNC-1:0], scl_i};
            sda_sr_q <= {sda_sr_q[SYNC-1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_sr_q[SYNC-1];
    assign sda_lvl   = sda_sr_q[SYNC-1];
    assign scl_rise  = scl_sr_q[SYNC-1] & ~scl_sr_q[SYNC];
    assign scl_fall  = ~scl_sr_q[SYNC-1] & scl_sr_q[SYNC];
    assign start_det = scl_sr_q[SYNC-1] & scl_sr_q[SYNC] & sda_sr_q[SYNC] & ~sda_sr_q[SYNC-1];
    assign stop_det  = scl_sr_q[SYNC-1] & scl_sr_q[SYNC] & ~sda_sr_q[SYNC] & sda_sr_q[SYNC-1];
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ee2w_slave_engine.sv
module ee2w_slave_engine
    import ee2w_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int TWR_CYC     = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    localparam int PG_W     = ADDR_W - 8;
    localparam int STRAP_W  = 3 - PG_W;
    localparam int PAGE_N   = 1 << PAGE_W;
    localparam int ROW_W    = ADDR_W - PAGE_W;
    localparam int BUSY_LEN = (TWR_CYC < PAGE_N) ? PAGE_N : TWR_CYC;
    localparam int BCNT_W   = $clog2(BUSY_LEN + 1);

    typedef struct packed {
        ee2w_state_e               st;
        logic [3:0]                cnt;
        logic [7:0]                sh;
        logic                      oe;
        logic                      rd;
        logic [ADDR_W-1:0]         ptr;
        logic [PG_W-1:0]           pg;
        logic [ROW_W-1:0]          row;
        logic [PAGE_N-1:0][7:0]    pbuf;
        logic [PAGE_N-1:0]         mask;
        logic                      busy;
        logic [BCNT_W-1:0]         bcnt;
        logic [PAGE_W:0]           cidx;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [7:0]        mem_wd, mem_rd;

    ee2w_line_cond #(.SYNC(SYNC_STAGES)) i_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ee2w_store #(.AW(ADDR_W), .DW(8)) i_store (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .raddr(q.ptr), .rdata(mem_rd)
    );

    always_comb begin
        logic [PAGE_W-1:0] cp_idx;
        d      = q;
        mem_we = 1'b0;
        mem_wa = '0;
        mem_wd = '0;
        cp_idx = q.cidx[PAGE_W-1:0];
        if (q.busy) begin
            // copy one buffered byte per clock while the bus is ignored
            if (!q.cidx[PAGE_W]) begin
                if (q.mask[cp_idx]) begin
                    mem_we = 1'b1;
                    mem_wa = {q.row, cp_idx};
                    mem_wd = q.pbuf[cp_idx];
                end
                d.cidx = q.cidx + 1'b1;
            end
            if (q.bcnt == '0) begin
                d.busy = 1'b0;
                d.mask = '0;
            end else begin
                d.bcnt = q.bcnt - 1'b1;
            end
        end else if (start_det) begin
            d.st   = S_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.mask = '0;
        end else if (stop_det) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
            if (|q.mask) begin
                d.busy = 1'b1;
                d.bcnt = BCNT_W'(BUSY_LEN - 1);
                d.cidx = '0;
                if (wp_i) d.mask = '0;
            end
        end else begin
            unique case (q.st)
                S_DEV, S_WADR, S_WDAT: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == S_DEV) begin
                            if (q.sh[7:4] == DEV_CODE && q.sh[3 -: STRAP_W] == strap_i[STRAP_W-1:0]) begin
                                d.oe = 1'b1;
                                d.st = S_DACK;
                                d.pg = q.sh[PG_W:1];
                                d.rd = q.sh[0];
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else if (q.st == S_WADR) begin
                            d.ptr = {q.pg, q.sh};
                            d.oe  = 1'b1;
                            d.st  = S_WAACK;
                        end else begin
                            d.pbuf[q.ptr[PAGE_W-1:0]] = q.sh;
                            d.mask[q.ptr[PAGE_W-1:0]] = 1'b1;
                            d.row                     = q.ptr[ADDR_W-1:PAGE_W];
                            d.ptr[PAGE_W-1:0]         = q.ptr[PAGE_W-1:0] + 1'b1;
                            d.oe                      = 1'b1;
                            d.st                      = S_WDACK;
                        end
                    end
                end
                S_DACK, S_WAACK, S_WDACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.st == S_DACK && q.rd) begin
                            d.sh  = mem_rd;
                            d.ptr = q.ptr + 1'b1;
                            d.oe  = ~mem_rd[7];
                            d.st  = S_RDAT;
                        end else if (q.st == S_DACK) begin
                            d.st = S_WADR;
                        end else begin
                            d.st = S_WDAT;
                        end
                    end
                end
                S_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe = 1'b0;
                            d.st = S_RACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = S_IDLE;
                    end else if (scl_fall) begin
                        d.sh  = mem_rd;
                        d.ptr = q.ptr + 1'b1;
                        d.oe  = ~mem_rd[7];
                        d.cnt = '0;
                        d.st  = S_RDAT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = q.oe;

    // R1: a start outside the busy period opens a fresh device-address byte
    a_r1_start_opens_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !q.busy) |=> (q.st == S_DEV && q.cnt == 4'd0));

    // R2: a chip-select mismatch never leads to a pulled-low ninth bit
    a_r2_nack_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_fall && !q.busy && q.st == S_DEV && q.cnt == 4'd8 &&
              q.sh[3 -: STRAP_W] != strap_i[STRAP_W-1:0]) |-> !q.oe);

    // R3: drive is stable while the bus clock stays high
    a_r3_drive_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(q.oe));

    // R6: silent during the busy period
    a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !q.oe);

    // R7: protection at the stop leaves nothing to copy
    a_r7_wp_empties_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.busy) && $past(wp_i)) |-> (q.mask == '0));

    // R10: host not-acknowledge ends the read
    a_r10_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.st == S_RACK && scl_rise && sda_s && !q.busy && !start_det && !stop_det)
        |-> (q.st == S_IDLE));
endmodule

// File: tb/test_ee2w_slave_engine.sv
module test_ee2w_slave_engine;
    localparam int         Q     = 8;
    localparam logic [1:0] STRAP = 2'b10;
    localparam int         NVEC  = 6;
    // {address[8:0], data[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        17'h000AA, 17'h0FF5C, 17'h100C3, 17'h1FF3E, 17'h05512, 17'h1A7E1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   checks = 0;
    int   fails = 0;
    logic [7:0] rbuf [16];
    bit   ack;
    int   polls;

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    ee2w_slave_engine #(.TWR_CYC(1000)) i_ee2w_slave_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        a = !sda_bus; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] dat);
        bit s1, s2, steady;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            s1 = sda_bus; tick(Q);
            s2 = sda_bus;
            if (s1 != s2) steady = 1'b0;
            dat = {dat[6:0], s1};
            scl = 1'b0;
        end
        chk(steady, "R3 data steady while clock high", int'(steady), 1);
        tick(Q / 2);
        sda_m = !mack; tick(Q);
        scl = 1'b1;    tick(2 * Q);
        scl = 1'b0;    tick(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic pg, input logic rd);
        return {4'b1010, STRAP, pg, rd};
    endfunction

    task automatic page_write(input logic [8:0] a, input int n, input logic [7:0] base);
        bus_start();
        send_byte(dev(a[8], 1'b0), ack); chk(ack, "R2 device ack (write)", int'(ack), 1);
        send_byte(a[7:0], ack);          chk(ack, "R4 word address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), ack);
            chk(ack, "R5 data byte ack", int'(ack), 1);
        end
        bus_stop();
    endtask

    task automatic wait_ready(output int p);
        bit a;
        p = 0;
        do begin
            bus_start();
            send_byte(dev(1'b0, 1'b0), a);
            bus_stop();
            p++;
        end while (!a && p < 50);
    endtask

    task automatic rd_seq(input logic [8:0] a, input int n);
        bus_start();
        send_byte(dev(a[8], 1'b0), ack); chk(ack, "R9 dummy write ack", int'(ack), 1);
        send_byte(a[7:0], ack);          chk(ack, "R9 address ack", int'(ack), 1);
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack); chk(ack, "R9 read device ack", int'(ack), 1);
        for (int i = 0; i < n; i++) read_byte(i < n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(10);
        chk(sda_oe == 1'b0, "R12 drive released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(10);
        chk(sda_oe == 1'b0, "R12 drive released after reset", int'(sda_oe), 0);

        // R12: not busy right after reset, pointer is 0
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        chk(ack, "R12 idle and not busy after reset", int'(ack), 1);
        bus_stop();

        // main table: byte write, wait, random read back
        for (int v = 0; v < NVEC; v++) begin
            page_write(VEC[v][16:8], 1, VEC[v][7:0]);
            bus_start();
            send_byte(dev(1'b0, 1'b0), ack);
            chk(!ack, "R6 poll right after stop is not acknowledged", int'(ack), 0);
            bus_stop();
            wait_ready(polls);
            chk(polls < 50, "R6 acknowledge returns after busy", polls, 1);
            rd_seq(VEC[v][16:8], 1);
            chk(rbuf[0] == VEC[v][7:0], "R4 R9 read back", rbuf[0], VEC[v][7:0]);
        end

        // R2: wrong strap bits and wrong device code
        bus_start();
        send_byte({4'b1010, ~STRAP, 2'b00}, ack);
        chk(!ack, "R2 strap mismatch not acknowledged", int'(ack), 0);
        bus_start();
        send_byte({4'b1011, STRAP, 2'b00}, ack);
        chk(!ack, "R2 code mismatch not acknowledged", int'(ack), 0);
        // R1: a start right after a mismatch is accepted
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        chk(ack, "R1 start after mismatch accepted", int'(ack), 1);
        bus_stop();
        // R1: after stop, a byte without start is ignored
        send_byte(dev(1'b0, 1'b0), ack);
        chk(!ack, "R1 byte without start ignored", int'(ack), 0);
        bus_stop();

        // R11: address-only write, no busy period, pointer loaded
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack);
        chk(ack, "R11 no busy after address-only write", int'(ack), 1);
        read_byte(1'b0, rbuf[0]);
        bus_stop();
        chk(rbuf[0] == 8'h5C, "R11 pointer loaded", rbuf[0], 8'h5C);

        // R8: current-address read continues at last+1, page bit of read ignored
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack);
        chk(ack, "R8 current read ack", int'(ack), 1);
        read_byte(1'b0, rbuf[0]);
        bus_stop();
        chk(rbuf[0] == 8'hC3, "R8 current address read", rbuf[0], 8'hC3);

        // R10: sequential read wraps 0x1FF -> 0x000
        rd_seq(9'h1FF, 2);
        chk(rbuf[0] == 8'h3E, "R10 first byte", rbuf[0], 8'h3E);
        chk(rbuf[1] == 8'hAA, "R10 wrap to 0x000", rbuf[1], 8'hAA);
        // R10: after the host not-acknowledge the block answers no further bits
        chk(sda_oe == 1'b0, "R10 read ended after nack", int'(sda_oe), 0);

        // R5: 17 bytes into one page wrap onto the first byte
        page_write(9'h130, 17, 8'h40);
        wait_ready(polls);
        rd_seq(9'h130, 16);
        chk(rbuf[0] == 8'h50, "R5 17th byte overwrote page start", rbuf[0], 8'h50);
        for (int i = 1; i < 16; i++)
            chk(rbuf[i] == 8'h40 + 8'(i), "R5 page byte", rbuf[i], 8'h40 + i);

        // R7: protected write is acknowledged but not stored
        wp = 1'b1;
        page_write(9'h055, 1, 8'h77);
        wait_ready(polls);
        wp = 1'b0;
        rd_seq(9'h055, 1);
        chk(rbuf[0] == 8'h12, "R7 protected location unchanged", rbuf[0], 8'h12);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule